// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers the event flags of a serial-bus controller and turns them into one interrupt line and a numeric vector. Seven event sources arrive as one-cycle pulses from the bus protocol engine. Each pulse sets a pending flag that stays set until software clears it. An enable mask decides which pending flags are reported. The highest-priority pending, enabled event appears as a small code in the vector register.

Software uses the block through a 16-bit register port. It programs the mask and inspects a status word. That word shows four of the pending flags at fixed, sparse bit positions, plus two live bus conditions. Software then services the block by reading the vector register over and over. Each read returns one code and retires that event. A read that returns zero means nothing enabled is left pending. The access-ready and stop-detected flags can also be cleared by writing 1 to their status bits.

Register map, selected by `reg_addr`: 0 is the enable mask (read/write), 1 is status (read, write-1-to-clear on selected bits), 2 is the vector (read only), and 3 is reserved and reads as zero.

Top module: `evt_vector_unit`

## Requirements
- R1: After synchronous reset, the mask, all pending flags, `irq_o` and `reg_rdata` are zero.
- R2: The mask register at address 0 is read/write and 7 bits wide. Bit 0 enables arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected and 6 addressed as slave. Bits 15:7 read as zero.
- R3: A pulse on `evt_pulse[i]` sets pending flag i, using the same bit order as the mask. The flag holds until it is cleared. In the status word at address 1, pending arbitration lost shows at bit 0, no-acknowledge at bit 1, access ready at bit 2 and stop detected at bit 5.
- R4: Status bit 11 mirrors `rx_full_i` and status bit 12 mirrors `bus_busy_i`. These two inputs never produce a vector code and never drive `irq_o`.
- R5: A read of address 2 returns the code of the lowest-numbered enabled pending event. The codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected and 7 addressed as slave. The read returns 0 when nothing enabled is pending.
- R6: A vector read that returns a nonzero code clears that event's pending flag. Repeated reads therefore drain events in priority order and end with 0.
- R7: Writing 1 to status bit 2 clears the access-ready flag, and writing 1 to bit 5 clears the stop-detected flag. Writing to any other status bit has no effect.
- R8: When an event pulse arrives in the same cycle as a clear of the same flag, the flag stays set. This holds whether the clear comes from a vector read or from a status write.
- R9: A disabled event still sets its pending flag and still shows in status, but it is not reported by the vector or by `irq_o`. Enabling it later makes it reported.
- R10: `irq_o` is high exactly when some enabled flag is pending. It follows the flag and mask registers in the cycle after the edge that updates them.
- R11: `reg_rdata` is registered. It carries the selected register in the cycle after a read strobe and is zero otherwise. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| evt_pulse | input | 7 | One-cycle event pulses, mask bit order |
| rx_full_i | input | 1 | Receive shift register full level |
| bus_busy_i | input | 1 | Bus busy level |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is a new event landing in the very cycle its flag is being cleared. In that cycle the set must win over the clear. The bench reaches it with a single-cycle bus task that drives the read or write strobe and `evt_pulse` on the same falling edge. It does this twice: once with a vector read that retires arbitration lost, and once with a write-1-to-clear of access ready. Draining sequences that start from several events pending at once, with parts of the mask closed, cover both the priority order and the masking.

// File: rtl/evt_vec_pkg.sv
package evt_vec_pkg;

    localparam int N_EVT  = 7;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int CODE_W = $clog2(N_EVT + 1);

    // event index = mask bit position; vector code = index + 1
    localparam int EV_ARB   = 0;
    localparam int EV_NACK  = 1;
    localparam int EV_ARDY  = 2;
    localparam int EV_RXRDY = 3;
    localparam int EV_TXRDY = 4;
    localparam int EV_STOP  = 5;
    localparam int EV_SLV   = 6;

    // status word bit positions
    localparam int ST_ARB    = 0;
    localparam int ST_NACK   = 1;
    localparam int ST_ARDY   = 2;
    localparam int ST_STOP   = 5;
    localparam int ST_RXFULL = 11;
    localparam int ST_BUSY   = 12;

    typedef logic [N_EVT-1:0]  evt_vec_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK = 2'd0,
        A_STAT = 2'd1,
        A_VEC  = 2'd2,
        A_RSVD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic      we;
        logic      re;
        reg_addr_e addr;
        word_t     wdata;
    } reg_req_t;

    // isolate the lowest set bit
    function automatic evt_vec_t lowest_onehot(evt_vec_t v);
        evt_vec_t neg;
        neg = ~v + evt_vec_t'(1);
        return v & neg;
    endfunction

    function automatic code_t onehot_to_code(evt_vec_t oh);
        code_t c;
        c = '0;
        for (int i = 0; i < N_EVT; i++) begin
            if (oh[i]) c = code_t'(i + 1);
        end
        return c;
    endfunction

    function automatic word_t pack_status(evt_vec_t pend, logic rxfull, logic busy);
        word_t s;
        s            = '0;
        s[ST_ARB]    = pend[EV_ARB];
        s[ST_NACK]   = pend[EV_NACK];
        s[ST_ARDY]   = pend[EV_ARDY];
        s[ST_STOP]   = pend[EV_STOP];
        s[ST_RXFULL] = rxfull;
        s[ST_BUSY]   = busy;
        return s;
    endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
    import evt_vec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t set_i,
    input  evt_vec_t clr_i,
    output evt_vec_t pend_o
);

    evt_vec_t pend_q;

    // set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < N_EVT; g++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> pend_o[g]); // R8
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !set_i[g]) |=> !pend_o[g]); // R6
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[g] && !set_i[g]) |=> $stable(pend_o[g])); // R3
    end

endmodule

// File: rtl/evt_prio_sel.sv
module evt_prio_sel
    import evt_vec_pkg::*;
(
    input  evt_vec_t pend_i,
    input  evt_vec_t mask_i,
    output evt_vec_t grant_o,
    output code_t    code_o
);

    evt_vec_t live;

    always_comb begin
        live    = pend_i & mask_i;
        grant_o = lowest_onehot(live);
        code_o  = onehot_to_code(grant_o);
    end

endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
    import evt_vec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req_i,
    input  evt_vec_t grant_i,
    input  code_t    code_i,
    input  word_t    status_i,
    output evt_vec_t mask_o,
    output evt_vec_t clr_o,
    output word_t    rdata_o
);

    logic     wr_mask, wr_stat, rd_vec;
    evt_vec_t mask_q;
    word_t    rd_mux;
    word_t    rdata_q;
    logic     unused_wdata_hi;

    assign wr_mask = req_i.we && (req_i.addr == A_MASK);
    assign wr_stat = req_i.we && (req_i.addr == A_STAT);
    assign rd_vec  = req_i.re && (req_i.addr == A_VEC);
    assign unused_wdata_hi = ^req_i.wdata[DATA_W-1:N_EVT];

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (wr_mask) mask_q <= req_i.wdata[N_EVT-1:0];
    end

    // clear requests: vector read retires granted event; W1C on two status bits
    always_comb begin
        clr_o = '0;
        if (rd_vec) clr_o = clr_o | grant_i;
        if (wr_stat) begin
            clr_o[EV_ARDY] = clr_o[EV_ARDY] | req_i.wdata[ST_ARDY];
            clr_o[EV_STOP] = clr_o[EV_STOP] | req_i.wdata[ST_STOP];
        end
    end

    always_comb begin
        unique case (req_i.addr)
            A_MASK:  rd_mux = word_t'(mask_q);
            A_STAT:  rd_mux = status_i;
            A_VEC:   rd_mux = word_t'(code_i);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata_q <= '0;
        else if (req_i.re) rdata_q <= rd_mux;
        else               rdata_q <= '0;
    end

    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_i.re |=> (rdata_o == '0)); // R11
    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_o == $past(req_i.wdata[N_EVT-1:0]))); // R2
    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !wr_mask |=> $stable(mask_o)); // R2

endmodule

// File: rtl/evt_vector_unit.sv
module evt_vector_unit
    import evt_vec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic        reg_we,
    input  logic        reg_re,
    output logic [15:0] reg_rdata,
    input  logic [6:0]  evt_pulse,
    input  logic        rx_full_i,
    input  logic        bus_busy_i,
    output logic        irq_o
);

    reg_req_t req;
    evt_vec_t pend, mask, grant, clr;
    code_t    code;
    word_t    status;

    always_comb begin
        req.we    = reg_we;
        req.re    = reg_re;
        req.addr  = reg_addr_e'(reg_addr);
        req.wdata = reg_wdata;
    end

    evt_flag_bank u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_pulse),
        .clr_i  (clr),
        .pend_o (pend)
    );

    evt_prio_sel u_sel (
        .pend_i  (pend),
        .mask_i  (mask),
        .grant_o (grant),
        .code_o  (code)
    );

    assign status = pack_status(pend, rx_full_i, bus_busy_i);

    evt_reg_port u_port (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .grant_i  (grant),
        .code_i   (code),
        .status_i (status),
        .mask_o   (mask),
        .clr_o    (clr),
        .rdata_o  (reg_rdata)
    );

    assign irq_o = |(pend & mask);

    AST_IRQ_CODE_AGREE: assert property (@(posedge clk) disable iff (rst)
        irq_o == (code != '0)); // R10
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R5
    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (grant & ~mask) == '0); // R9
    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
        (grant & ~pend) == '0); // R5

endmodule

// File: tb/evt_vector_unit_tb.sv
module evt_vector_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [15:0] reg_rdata;
    logic [6:0]  evt_pulse = '0;
    logic        rx_full_i = 1'b0;
    logic        bus_busy_i = 1'b0;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    evt_vector_unit u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .rx_full_i(rx_full_i), .bus_busy_i(bus_busy_i),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // one bus cycle: starts and ends at a falling edge
    task automatic cyc(input logic we, input logic re, input logic [1:0] a,
                       input logic [15:0] wd, input logic [6:0] ev,
                       output logic [15:0] rd);
        reg_we = we; reg_re = re; reg_addr = a; reg_wdata = wd; evt_pulse = ev;
        @(posedge clk);
        @(negedge clk);
        rd = reg_rdata;
        reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0; evt_pulse = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        logic [15:0] x;
        cyc(1'b1, 1'b0, a, d, '0, x);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        cyc(1'b0, 1'b1, a, '0, '0, d);
    endtask

    task automatic pulse(input logic [6:0] ev);
        logic [15:0] x;
        cyc(1'b0, 1'b0, '0, '0, ev, x);
    endtask

    task automatic expect_drain(input string req, input int n, input int codes[8]);
        logic [15:0] d;
        for (int i = 0; i < n; i++) begin
            rd(2'd2, d);
            check(req, d, 16'(codes[i]));
        end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R1 rdata", reg_rdata, 16'h0);
        check("R1 irq", {15'h0, irq_o}, 16'h0);
        rd(2'd0, d); check("R1 mask", d, 16'h0);
        rd(2'd1, d); check("R1 status", d, 16'h0);
        rd(2'd2, d); check("R1 vector", d, 16'h0);
        check("R11 rdata idle", reg_rdata, 16'h0);
    endtask

    task automatic t_mask_rw;
        logic [15:0] d;
        wr(2'd0, 16'hFFFF); rd(2'd0, d); check("R2 mask upper zero", d, 16'h007F);
        wr(2'd0, 16'h0015); rd(2'd0, d); check("R2 mask pattern", d, 16'h0015);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_layout_drain;
        logic [15:0] d;
        int c[8] = '{1, 2, 3, 4, 5, 6, 7, 0};
        pulse(7'h7F);
        rd(2'd1, d); check("R3 status layout", d, 16'h0027);
        check("R9 irq masked", {15'h0, irq_o}, 16'h0);
        rd(2'd2, d); check("R9 vector masked", d, 16'h0);
        rx_full_i = 1'b1; bus_busy_i = 1'b1;
        rd(2'd1, d); check("R4 level bits", d, 16'h1827);
        wr(2'd0, 16'h007F);
        check("R10 irq on enable", {15'h0, irq_o}, 16'h1);
        expect_drain("R6 R5 drain order", 8, c);
        check("R4 levels no irq", {15'h0, irq_o}, 16'h0);
        rd(2'd2, d); check("R4 levels no code", d, 16'h0);
        rx_full_i = 1'b0; bus_busy_i = 1'b0;
    endtask

    task automatic t_priority;
        int c[8] = '{4, 7, 0, 0, 0, 0, 0, 0};
        pulse(7'b1001000);
        check("R10 irq pending", {15'h0, irq_o}, 16'h1);
        expect_drain("R5 priority", 3, c);
    endtask

    task automatic t_w1c;
        logic [15:0] d;
        int c[8] = '{1, 2, 4, 5, 7, 0, 0, 0};
        wr(2'd0, 16'h0000);
        pulse(7'h7F);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); check("R7 w1c selective", d, 16'h0003);
        wr(2'd0, 16'h007F);
        expect_drain("R7 remaining events", 6, c);
    endtask

    task automatic t_vec_write;
        logic [15:0] d;
        int c[8] = '{2, 0, 0, 0, 0, 0, 0, 0};
        pulse(7'b0000010);
        wr(2'd2, 16'hFFFF);
        rd(2'd1, d); check("R11 vector write ignored", d, 16'h0002);
        expect_drain("R11 drain", 2, c);
    endtask

    task automatic t_set_wins;
        logic [15:0] d;
        pulse(7'b0000100);
        cyc(1'b1, 1'b0, 2'd1, 16'h0004, 7'b0000100, d);
        rd(2'd1, d); check("R8 set beats w1c", d, 16'h0004);
        wr(2'd1, 16'h0004);
        rd(2'd1, d); check("R7 ardy cleared", d, 16'h0000);
        pulse(7'b0000001);
        cyc(1'b0, 1'b1, 2'd2, '0, 7'b0000001, d);
        check("R8 read code", d, 16'h0001);
        rd(2'd1, d); check("R8 set beats vector read", d, 16'h0001);
        rd(2'd2, d); check("R6 second read", d, 16'h0001);
        rd(2'd2, d); check("R6 empty", d, 16'h0000);
    endtask

    task automatic t_enable_later;
        logic [15:0] d;
        wr(2'd0, 16'h0010);
        pulse(7'b0001000);
        check("R9 irq disabled", {15'h0, irq_o}, 16'h0);
        rd(2'd2, d); check("R9 vector disabled", d, 16'h0);
        wr(2'd0, 16'h0018);
        check("R10 irq after enable", {15'h0, irq_o}, 16'h1);
        rd(2'd2, d); check("R9 reported after enable", d, 16'h0004);
        check("R10 irq after drain", {15'h0, irq_o}, 16'h0);
        pulse(7'b0010000);
        check("R10 irq next cycle", {15'h0, irq_o}, 16'h1);
        rd(2'd2, d); check("R5 tx code", d, 16'h0005);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mask_rw();
        t_layout_drain();
        t_priority();
        t_w1c();
        t_vec_write();
        t_set_wins();
        t_enable_later();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule